// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This block is a 64-bit execution unit for bit-field operations. It has three operations on a single datapath. The first pulls a field out of a source word and fills the bits above it with zeros. The second does the same but fills those bits with copies of the field's top bit. The third writes the low bits of a source word into a field of a destination word and keeps every other destination bit.

A field is described by its lowest bit position and a second 6-bit value. That second value is either a bit count or the position of the field's top bit, as chosen by a mode input. Both values come either from one packed 12-bit control word or from two separate immediate inputs.

Every operation is accepted with an input strobe. Its result and an illegal-field flag come back registered, one clock later, with an output strobe. The unit has no other state and can accept a new operation on every clock.

Top module: `bitfield_unit`

## Requirements
- R1: With `opInsert`=0 and `opSigned`=0, result bits [w-1:0] equal source bits [lsb+w-1:lsb], where w is the effective width. Every result bit at position w or above is 0.
- R2: With `opInsert`=0 and `opSigned`=1, result bits [w-1:0] hold the field. Every result bit at position w or above equals source bit lsb+w-1, the field's top bit.
- R3: With `opInsert`=1, result bits [lsb+w-1:lsb] equal source bits [w-1:0]. Every other result bit equals the matching bit of `dstWord`.
- R4: With `usePacked`=1, the low bit position is taken from `ctrlWord[5:0]` and the count or top value from `ctrlWord[11:6]`. The immediate inputs are then ignored.
- R5: With `topMode`=0 the 6-bit high value is a count, and a count of 0 means a width of 64.
- R6: With `topMode`=1 the high value is the field's top bit position, and the count is top-lsb+1.
- R7: With `topMode`=1 and top < lsb, `illegal` is 1. An extract then returns all zeros, and an insert returns `dstWord` unchanged. In every other case `illegal` is 0.
- R8: When lsb+count exceeds 64, the effective width w is 64-lsb. The sign bit used by R2 is then source bit 63.
- R9: With `usePacked`=0, `immLsb` and `immHigh` play the roles of the two packed fields. The same field values give the same result on either path.
- R10: `outValid` is 1 in exactly the cycle after an edge at which `inValid` was 1. `result` and `illegal` are updated only by accepted operations. A synchronous active-high `rst` clears `outValid`.
- R11: `opSigned` has no effect on an insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation strobe |
| opInsert | input | 1 | 1 = insert, 0 = extract |
| opSigned | input | 1 | Extract fill: 1 = sign, 0 = zero |
| usePacked | input | 1 | 1 = descriptor from ctrlWord, 0 = from immediates |
| topMode | input | 1 | 1 = high value is top bit, 0 = high value is count |
| ctrlWord | input | 12 | Packed descriptor: [5:0] low bit, [11:6] count or top |
| immLsb | input | 6 | Immediate low bit position |
| immHigh | input | 6 | Immediate count or top bit |
| srcWord | input | 64 | Source operand |
| dstWord | input | 64 | Destination operand, read by insert |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| result | output | 64 | Registered result |
| illegal | output | 1 | Registered illegal-field flag |

## Verification
The bench aims at fields that start above bit 0. A unit that forgot the right shift would return the wrong byte there. It checks a count of 0, where a unit that misread the code would produce an empty mask instead of a full 64-bit one. It drives fields that run past bit 63: without clipping, the sign would come from a wrapped bit index and the insert mask would spill. It also drives top-below-low descriptors, where a wrong design would leak data or corrupt the destination. Finally it compares the packed and immediate paths for the same field values, and runs inserts with the sign select set, to catch a swapped field or a stray sign fill.

// File: rtl/bitfield_pkg.sv
package bitfield_pkg;
  localparam int DATA_W = 64;
  localparam int POS_W  = $clog2(DATA_W);
  localparam int CNT_W  = POS_W + 1;

  // Strobes and decoded field passed from control to datapath
  typedef struct packed {
    logic             load;
    logic             insert;
    logic             signExt;
    logic             badField;
    logic [POS_W-1:0] lsb;
    logic [CNT_W-1:0] width;
  } bf_ctrl_t;
endpackage

// File: rtl/bitfield_ctrl.sv
module bitfield_ctrl
  import bitfield_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic                 opInsert,
  input  logic                 opSigned,
  input  logic                 usePacked,
  input  logic                 topMode,
  input  logic [2*POS_W-1:0]   ctrlWord,
  input  logic [POS_W-1:0]     immLsb,
  input  logic [POS_W-1:0]     immHigh,
  output bf_ctrl_t             ctrl,
  output logic                 outValid,
  output logic                 illegal
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [POS_W-1:0] selLsb, selHigh;
  logic [CNT_W-1:0] rawCount, room, effWidth;
  logic             badField;

  always_comb begin
    selLsb  = usePacked ? ctrlWord[POS_W-1:0]       : immLsb;
    selHigh = usePacked ? ctrlWord[2*POS_W-1:POS_W] : immHigh;
    badField = topMode && (selHigh < selLsb);
    if (topMode)
      rawCount = {1'b0, selHigh} - {1'b0, selLsb} + CNT_W'(1);
    else if (selHigh == '0)
      rawCount = FULL;
    else
      rawCount = {1'b0, selHigh};
    room     = FULL - {1'b0, selLsb};
    effWidth = (rawCount > room) ? room : rawCount;
  end

  always_comb begin
    ctrl.load     = inValid;
    ctrl.insert   = opInsert;
    ctrl.signExt  = opSigned & ~opInsert;
    ctrl.badField = badField;
    ctrl.lsb      = selLsb;
    ctrl.width    = badField ? '0 : effWidth;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) illegal <= badField;
    end
  end
endmodule

// File: rtl/bitfield_dp.sv
module bitfield_dp
  import bitfield_pkg::*;
(
  input  logic              clk,
  input  bf_ctrl_t          ctrl,
  input  logic [DATA_W-1:0] srcWord,
  input  logic [DATA_W-1:0] dstWord,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] fieldMask, shifted, extractVal, insMask, insertVal, nextResult;
  logic [POS_W-1:0]  topIdx;
  logic              signBit;

  always_comb begin
    if (ctrl.width >= CNT_W'(DATA_W))
      fieldMask = '1;
    else
      fieldMask = (DATA_W'(1) << ctrl.width) - DATA_W'(1);
    shifted    = srcWord >> ctrl.lsb;
    topIdx     = POS_W'(ctrl.width - CNT_W'(1));
    signBit    = shifted[topIdx];
    extractVal = (shifted & fieldMask) |
                 ((ctrl.signExt && signBit) ? ~fieldMask : '0);
    insMask    = fieldMask << ctrl.lsb;
    insertVal  = (dstWord & ~insMask) | ((srcWord << ctrl.lsb) & insMask);
    if (ctrl.badField)
      nextResult = ctrl.insert ? dstWord : '0;
    else
      nextResult = ctrl.insert ? insertVal : extractVal;
  end

  always_ff @(posedge clk) begin
    if (ctrl.load) result <= nextResult;
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bitfield_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              opInsert,
  input  logic              opSigned,
  input  logic              usePacked,
  input  logic              topMode,
  input  logic [11:0]       ctrlWord,
  input  logic [5:0]        immLsb,
  input  logic [5:0]        immHigh,
  input  logic [63:0]       srcWord,
  input  logic [63:0]       dstWord,
  output logic              outValid,
  output logic [63:0]       result,
  output logic              illegal
);
  bf_ctrl_t ctrl;

  bitfield_ctrl ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .opInsert(opInsert),
    .opSigned(opSigned), .usePacked(usePacked), .topMode(topMode),
    .ctrlWord(ctrlWord), .immLsb(immLsb), .immHigh(immHigh),
    .ctrl(ctrl), .outValid(outValid), .illegal(illegal)
  );

  bitfield_dp dp_i (
    .clk(clk), .ctrl(ctrl), .srcWord(srcWord), .dstWord(dstWord),
    .result(result)
  );
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic        opInsert,
  input logic        usePacked,
  input logic        topMode,
  input logic [11:0] ctrlWord,
  input logic [5:0]  immLsb,
  input logic [5:0]  immHigh,
  input logic [63:0] dstWord,
  input logic        outValid,
  input logic [63:0] result,
  input logic        illegal
);
  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  // R10
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !outValid);
  // R7
  bad_extract_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !opInsert) ##1 illegal |-> result == '0);
  // R7
  bad_insert_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && opInsert) ##1 illegal |-> result == $past(dstWord));
  // R7
  count_mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !topMode) |=> !illegal);
  // R7
  top_below_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && topMode && usePacked && (ctrlWord[11:6] < ctrlWord[5:0])) |=> illegal);
  // R9
  imm_below_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && topMode && !usePacked && (immHigh < immLsb)) |=> illegal);
endmodule

bind bitfield_unit bitfield_unit_chk chk_i (
  .clk(clk), .rst(rst), .inValid(inValid), .opInsert(opInsert),
  .usePacked(usePacked), .topMode(topMode), .ctrlWord(ctrlWord),
  .immLsb(immLsb), .immHigh(immHigh), .dstWord(dstWord),
  .outValid(outValid), .result(result), .illegal(illegal)
);

// File: tb/bitfield_unit_tb_top.sv
module bitfield_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid, opInsert, opSigned, usePacked, topMode;
  logic [11:0] ctrlWord;
  logic [5:0]  immLsb, immHigh;
  logic [63:0] srcWord, dstWord;
  logic        outValid, illegal;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  logic [63:0] expRes;
  logic        expBad;

  always #10 clk = ~clk;

  bitfield_unit dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .opInsert(opInsert),
    .opSigned(opSigned), .usePacked(usePacked), .topMode(topMode),
    .ctrlWord(ctrlWord), .immLsb(immLsb), .immHigh(immHigh),
    .srcWord(srcWord), .dstWord(dstWord), .outValid(outValid),
    .result(result), .illegal(illegal)
  );

  // Bit-by-bit reference model built from the requirements
  function automatic void refModel(input logic ins, input logic sgn, input logic tm,
      input int lsb, input int hi, input logic [63:0] src, input logic [63:0] dst,
      output logic [63:0] r, output logic bad);
    int cnt, w;
    bad = tm && (hi < lsb);
    if (tm) cnt = hi - lsb + 1;
    else    cnt = (hi == 0) ? 64 : hi;
    w = (lsb + cnt > 64) ? 64 - lsb : cnt;
    if (bad) begin
      r = ins ? dst : 64'd0;
    end else if (ins) begin
      r = dst;
      for (int i = 0; i < w; i++) r[lsb+i] = src[i];
    end else begin
      for (int i = 0; i < 64; i++)
        r[i] = (i < w) ? src[lsb+i] : (sgn ? src[lsb+w-1] : 1'b0);
    end
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic runOp(input string tag, input logic ins, input logic sgn,
      input logic pk, input logic tm, input int lsb, input int hi,
      input logic [63:0] src, input logic [63:0] dst);
    @(negedge clk);
    inValid = 1'b1; opInsert = ins; opSigned = sgn; usePacked = pk; topMode = tm;
    srcWord = src; dstWord = dst;
    if (pk) begin
      ctrlWord = {6'(hi), 6'(lsb)};
      immLsb = 6'($urandom); immHigh = 6'($urandom);
    end else begin
      ctrlWord = 12'($urandom);
      immLsb = 6'(lsb); immHigh = 6'(hi);
    end
    refModel(ins, sgn, tm, lsb, hi, src, dst, expRes, expBad);
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " valid"}, {63'd0, outValid}, 64'd1);
    check({tag, " result"}, result, expRes);
    check({tag, " illegal"}, {63'd0, illegal}, {63'd0, expBad});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] held, a, b;
    void'($urandom(32'd4242));
    rst = 1'b1; inValid = 1'b0; opInsert = 1'b0; opSigned = 1'b0;
    usePacked = 1'b1; topMode = 1'b0; ctrlWord = '0; immLsb = '0; immHigh = '0;
    srcWord = '0; dstWord = '0;
    repeat (3) @(negedge clk);
    check("R10 reset outValid", {63'd0, outValid}, 64'd0);
    rst = 1'b0;

    runOp("R1 lsb0 cnt32", 0, 0, 1, 0, 0, 32, 64'hF123_4567_89AB_CDEF, 64'd0);
    runOp("R1 R4 byte1 zx", 0, 0, 1, 0, 8, 8, 64'h0000_0000_0000_A5C3, 64'd0);
    runOp("R2 byte1 sx", 0, 1, 1, 0, 8, 8, 64'h0000_0000_0000_8001, 64'd0);
    runOp("R2 lsb0 cnt16 positive", 0, 1, 1, 0, 0, 16, 64'hFFFF_FFFF_FFFF_7FFF, 64'd0);
    runOp("R3 insert mid", 1, 0, 1, 0, 20, 12, 64'h0000_0000_0000_0ABC, 64'hFFFF_FFFF_FFFF_FFFF);
    runOp("R11 insert signed", 1, 1, 1, 0, 4, 8, 64'h0000_0000_0000_00FF, 64'd0);
    runOp("R5 count0 full", 0, 1, 1, 0, 0, 0, 64'h8765_4321_0FED_CBA9, 64'd0);
    runOp("R5 insert count0", 1, 0, 1, 0, 0, 0, 64'h1111_2222_3333_4444, 64'hAAAA_AAAA_AAAA_AAAA);
    runOp("R6 top mode", 0, 0, 1, 1, 4, 11, 64'h0000_0000_0000_0FF0, 64'd0);
    runOp("R6 top equals lsb", 0, 1, 1, 1, 63, 63, 64'h8000_0000_0000_0000, 64'd0);
    runOp("R7 bad extract", 0, 1, 1, 1, 10, 9, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    runOp("R7 bad insert", 1, 0, 1, 1, 40, 2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF);
    runOp("R8 clip sx", 0, 1, 1, 0, 60, 8, 64'h8000_0000_0000_0000, 64'd0);
    runOp("R8 clip insert", 1, 0, 1, 0, 62, 10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    runOp("R9 imm byte1 sx", 0, 1, 0, 0, 8, 8, 64'h0000_0000_0000_8001, 64'd0);
    runOp("R9 imm top bad", 0, 0, 0, 1, 5, 4, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);

    // R9: same field through both paths must agree
    for (int k = 0; k < 40; k++) begin
      int lsb, hi; logic tm, sg, ins;
      logic [63:0] s, d;
      lsb = int'($urandom_range(63)); hi = int'($urandom_range(63));
      tm = 1'($urandom); sg = 1'($urandom); ins = 1'($urandom);
      s = {$urandom, $urandom}; d = {$urandom, $urandom};
      runOp("R9 packed", ins, sg, 1, tm, lsb, hi, s, d);
      a = result;
      runOp("R9 immediate", ins, sg, 0, tm, lsb, hi, s, d);
      b = result;
      check("R9 paths agree", b, a);
    end

    // R10: idle cycles keep the result and drop the strobe
    held = result;
    @(negedge clk);
    srcWord = ~srcWord; dstWord = ~dstWord; ctrlWord = ~ctrlWord;
    @(negedge clk);
    check("R10 idle outValid", {63'd0, outValid}, 64'd0);
    check("R10 idle result held", result, held);

    // R10: reset while busy clears the strobe
    @(negedge clk);
    inValid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R10 reset clears valid", {63'd0, outValid}, 64'd0);
    rst = 1'b0; inValid = 1'b0;

    // Constrained random mix covering R1 R2 R3 R5 R6 R7 R8 R11
    for (int k = 0; k < 1500; k++) begin
      int lsb, hi;
      lsb = int'($urandom_range(63));
      hi  = ($urandom_range(7) == 0) ? 0 : int'($urandom_range(63));
      runOp("R1 R2 R3 random", 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), lsb, hi, {$urandom, $urandom}, {$urandom, $urandom});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule